// File: doc/BRIEF.md
# DRAM Bank Issue Arbiter

This block sits in front of a single DDR-style memory channel and decides, once per memory cycle, which bank may start its next access. Incoming requests carry an address and a read/write flag. The block decodes the address into a flat bank index, which combines the DIMM, rank and bank fields. It then parks the request in a small per-bank queue. Every cycle it scans the queue heads in round-robin order and releases at most one of them. A head is released only when every timing constraint allows it: its own bank must be idle, the shared bus must be free, a write must wait out the read-to-write turnaround, and a read to a new rank must wait out the rank-switch bubble.

The policy is closed-bank, so every issue keeps its bank busy for a fixed time. All timers count down by one per cycle and stop at zero. The countdown takes effect before the issue decision in the same cycle, so a timer loaded with N frees its resource exactly N cycles after the issue. The request input is a valid/ready stream and accepts at most one request per cycle. Ready is low only when the target bank queue is full and that queue's head is not issuing in the same cycle. A stalled request holds back every request behind it. The issue output is a registered one-cycle strobe that carries the bank, the rank and the read/write flag. It has no back-pressure.

The parameters must satisfy these limits: banks per rank, ranks per DIMM and DIMMs must each be powers of two, with at least two banks in total. The bank-busy and bus-busy times must be at least 1.

Top module: `dram_issue_arb`

## Requirements
- R1: The bank index is dimm*(ranks_per_dimm*banks_per_rank) + rank*banks_per_rank + bank. Each field is read from `req_addr` at its own low-bit parameter, and with the defaults bank = bit 4, rank = bit 5 and DIMM = bit 6. The rank reported on issue is the bank index divided by banks_per_rank.
- R2: A request is taken on a cycle with `req_valid` and `req_ready` both high. `req_ready` is high when the target queue holds fewer than QUEUE_DEPTH entries, or when that queue's head issues in the same cycle. A request held off this way blocks all later requests. An accepted request can issue no earlier than the cycle after acceptance, and its strobe appears one cycle after that.
- R3: Requests to one bank issue in arrival order.
- R4: Two issues to the same bank are at least BANK_BUSY cycles apart, and exactly that far apart when nothing else interferes.
- R5: Any two issues are at least BUS_BUSY cycles apart.
- R6: A write issues at least BUS_BUSY+RD_TO_WR cycles after a read. A write that follows a write needs only BUS_BUSY cycles.
- R7: A read whose rank differs from the rank of the previous issue must wait BUS_BUSY+RANK_SWITCH cycles when that issue was a read. It waits only BUS_BUSY cycles when the previous issue was a write or used the same rank.
- R8: When several heads may issue, the winner is the first one in ascending, wrapping bank order after the most recently issued bank. The pointer starts at the last bank after reset, and it moves only when a request issues.
- R9: Each accepted request produces exactly one `iss_valid` pulse, one cycle wide, with the correct bank, rank and write flag. A pulse is produced whenever some queue head meets all its constraints.
- R10: During and after reset, `iss_valid` is low and `req_ready` is high, all queues are empty and no timer blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | ADDR_W | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| iss_valid | output | 1 | One-cycle issue strobe |
| iss_bank | output | BANK_W | Flat bank index issued |
| iss_rank | output | RANK_W | Rank of the issued bank |
| iss_write | output | 1 | Issued request is a write |

## Verification
The bench goes after five corner cases.

- **Bubble lengths.** It measures the gap between issue strobes for read-read, read-write, write-write and write-read pairs, both within one rank and across ranks. A design that loads the wrong counter on a read or a write would show a gap one or two cycles off.
- **Pop-through on a full queue.** It fills a queue while the bank is busy and checks that the stalled request enters in the exact cycle the head leaves. A design without pop-through would lose a cycle, and one that ignores the full flag would overflow the queue.
- **Head-of-line blocking.** It checks that a request to another bank queued behind the stall waits with it.
- **Round-robin choice.** It builds two heads that become ready in the same cycle, with the arrival order opposite to the round-robin order. A design that served them by arrival, or from a pointer that never moves, would pick the wrong bank.
- **Address decode.** It sweeps every bank index under varied surrounding address bits. A decode that read the wrong field would send the request to the wrong bank.

// File: rtl/dram_arb_pkg.sv
package dram_arb_pkg;
  typedef enum logic {
    KIND_RD = 1'b0,
    KIND_WR = 1'b1
  } req_kind_e;
endpackage

// File: rtl/dram_bank_decode.sv
module dram_bank_decode #(
  parameter int ADDR_W         = 12,
  parameter int BANKS_PER_RANK = 2,
  parameter int RANKS_PER_DIMM = 2,
  parameter int DIMMS          = 2,
  parameter int BANK_LSB       = 4,
  parameter int RANK_LSB       = 5,
  parameter int DIMM_LSB       = 6,
  parameter int BANK_W         = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank_idx
);
  // field extraction in integer arithmetic so one-wide fields need no special case
  always_comb begin
    int f_bank;
    int f_rank;
    int f_dimm;
    f_bank = int'(addr >> BANK_LSB) & (BANKS_PER_RANK - 1);
    f_rank = int'(addr >> RANK_LSB) & (RANKS_PER_DIMM - 1);
    f_dimm = int'(addr >> DIMM_LSB) & (DIMMS - 1);
    bank_idx = BANK_W'(f_dimm * RANKS_PER_DIMM * BANKS_PER_RANK
                       + f_rank * BANKS_PER_RANK + f_bank);
  end
endmodule

// File: rtl/dram_bank_queue.sv
module dram_bank_queue
  import dram_arb_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  req_kind_e push_kind,
  input  logic      pop,
  output req_kind_e head_kind,
  output logic      not_empty,
  output logic      full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  req_kind_e          slots [DEPTH];
  logic [PTR_W-1:0]   rd_ptr, wr_ptr;
  logic [CNT_W-1:0]   fill;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= push_kind;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      case ({push, pop})
        2'b10:   fill <= fill + CNT_W'(1);
        2'b01:   fill <= fill - CNT_W'(1);
        default: fill <= fill;
      endcase
    end
  end

  assign head_kind = slots[rd_ptr];
  assign not_empty = (fill != '0);
  assign full      = (fill == CNT_W'(DEPTH));

  // R2: the stream edge never writes into a full queue unless its head leaves
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));
  // R9: the picker only pops a queue that holds a request
  p_pop_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> not_empty);
endmodule

// File: rtl/dram_timing_ctrs.sv
module dram_timing_ctrs #(
  parameter int NUM_BANKS   = 8,
  parameter int BANK_W      = 3,
  parameter int RANK_W      = 2,
  parameter int BANK_BUSY   = 6,
  parameter int BUS_BUSY    = 2,
  parameter int RD_TO_WR    = 1,
  parameter int RANK_SWITCH = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic [BANK_W-1:0]    fire_bank,
  input  logic [RANK_W-1:0]    fire_rank,
  input  logic                 fire_write,
  output logic [NUM_BANKS-1:0] bank_free,
  output logic                 bus_free,
  output logic                 wr_free,
  output logic                 newrank_free,
  output logic [RANK_W-1:0]    last_rank
);
  localparam int BB_W    = $clog2(BANK_BUSY + 1);
  localparam int EXTRA   = (RD_TO_WR > RANK_SWITCH) ? RD_TO_WR : RANK_SWITCH;
  localparam int BUS_MAX = BUS_BUSY + EXTRA;
  localparam int BUS_W   = $clog2(BUS_MAX + 1);

  // per-bank occupancy: decrement first, then decide, then reload on issue
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [BB_W-1:0] cnt_q, cnt_e;
    assign cnt_e = (cnt_q == '0) ? '0 : cnt_q - BB_W'(1);
    always_ff @(posedge clk) begin
      if (!rst_n)                                 cnt_q <= '0;
      else if (fire && fire_bank == BANK_W'(b))   cnt_q <= BB_W'(BANK_BUSY);
      else                                        cnt_q <= cnt_e;
    end
    assign bank_free[b] = (cnt_e == '0);
  end

  logic [BUS_W-1:0] basic_q, wrt_q, nrk_q;
  logic [BUS_W-1:0] basic_e, wrt_e, nrk_e;

  assign basic_e = (basic_q == '0) ? '0 : basic_q - BUS_W'(1);
  assign wrt_e   = (wrt_q   == '0) ? '0 : wrt_q   - BUS_W'(1);
  assign nrk_e   = (nrk_q   == '0) ? '0 : nrk_q   - BUS_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      basic_q   <= '0;
      wrt_q     <= '0;
      nrk_q     <= '0;
      last_rank <= '0;
    end else if (fire) begin
      basic_q   <= BUS_W'(BUS_BUSY);
      last_rank <= fire_rank;
      if (fire_write) begin
        wrt_q <= BUS_W'(BUS_BUSY);
        nrk_q <= BUS_W'(BUS_BUSY);
      end else begin
        wrt_q <= BUS_W'(BUS_BUSY + RD_TO_WR);
        nrk_q <= BUS_W'(BUS_BUSY + RANK_SWITCH);
      end
    end else begin
      basic_q <= basic_e;
      wrt_q   <= wrt_e;
      nrk_q   <= nrk_e;
    end
  end

  assign bus_free     = (basic_e == '0);
  assign wr_free      = (wrt_e == '0);
  assign newrank_free = (nrk_e == '0);
endmodule

// File: rtl/dram_rr_pick.sv
module dram_rr_pick #(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] elig,
  output logic                 grant_valid,
  output logic [BANK_W-1:0]    grant_idx
);
  logic [BANK_W-1:0] ptr_q;

  always_comb begin
    grant_valid = 1'b0;
    grant_idx   = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      int cand;
      cand = (int'(ptr_q) + 1 + i) % NUM_BANKS;
      if (!grant_valid && elig[cand]) begin
        grant_valid = 1'b1;
        grant_idx   = BANK_W'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           ptr_q <= BANK_W'(NUM_BANKS - 1);
    else if (grant_valid) ptr_q <= grant_idx;
  end
endmodule

// File: rtl/dram_issue_arb.sv
module dram_issue_arb
  import dram_arb_pkg::*;
#(
  parameter int ADDR_W         = 12,
  parameter int BANKS_PER_RANK = 2,
  parameter int RANKS_PER_DIMM = 2,
  parameter int DIMMS          = 2,
  parameter int BANK_LSB       = 4,
  parameter int RANK_LSB       = 5,
  parameter int DIMM_LSB       = 6,
  parameter int QUEUE_DEPTH    = 2,
  parameter int BANK_BUSY      = 6,
  parameter int BUS_BUSY       = 2,
  parameter int RD_TO_WR       = 1,
  parameter int RANK_SWITCH    = 1,
  localparam int NUM_BANKS     = BANKS_PER_RANK * RANKS_PER_DIMM * DIMMS,
  localparam int NUM_RANKS     = RANKS_PER_DIMM * DIMMS,
  localparam int BANK_W        = $clog2(NUM_BANKS),
  localparam int RANK_W        = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              iss_valid,
  output logic [BANK_W-1:0] iss_bank,
  output logic [RANK_W-1:0] iss_rank,
  output logic              iss_write
);
  logic [BANK_W-1:0]    req_bank;
  req_kind_e            req_kind;
  logic [NUM_BANKS-1:0] push_en, pop_en, q_nonempty, q_full, elig;
  req_kind_e            q_head [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_free;
  logic                 bus_free, wr_free, newrank_free;
  logic [RANK_W-1:0]    last_rank;
  logic                 grant_valid;
  logic [BANK_W-1:0]    grant_idx;
  logic [RANK_W-1:0]    grant_rank;
  logic                 grant_write;

  dram_bank_decode #(
    .ADDR_W(ADDR_W), .BANKS_PER_RANK(BANKS_PER_RANK), .RANKS_PER_DIMM(RANKS_PER_DIMM),
    .DIMMS(DIMMS), .BANK_LSB(BANK_LSB), .RANK_LSB(RANK_LSB), .DIMM_LSB(DIMM_LSB),
    .BANK_W(BANK_W)
  ) u_decode (
    .addr(req_addr),
    .bank_idx(req_bank)
  );

  assign req_kind  = req_write ? KIND_WR : KIND_RD;
  // a full queue still accepts when its head leaves in the same cycle
  assign req_ready = !q_full[req_bank] || (grant_valid && grant_idx == req_bank);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_q
    localparam logic [RANK_W-1:0] B_RANK = RANK_W'(b / BANKS_PER_RANK);
    logic head_is_wr;

    assign push_en[b] = req_valid && req_ready && (req_bank == BANK_W'(b));
    assign pop_en[b]  = grant_valid && (grant_idx == BANK_W'(b));

    dram_bank_queue #(.DEPTH(QUEUE_DEPTH)) u_queue (
      .clk(clk),
      .rst_n(rst_n),
      .push(push_en[b]),
      .push_kind(req_kind),
      .pop(pop_en[b]),
      .head_kind(q_head[b]),
      .not_empty(q_nonempty[b]),
      .full(q_full[b])
    );

    assign head_is_wr = (q_head[b] == KIND_WR);
    assign elig[b] = q_nonempty[b] && bank_free[b] && bus_free &&
                     (head_is_wr ? wr_free
                                 : ((B_RANK == last_rank) || newrank_free));
  end

  dram_rr_pick #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_pick (
    .clk(clk),
    .rst_n(rst_n),
    .elig(elig),
    .grant_valid(grant_valid),
    .grant_idx(grant_idx)
  );

  assign grant_rank  = RANK_W'(int'(grant_idx) / BANKS_PER_RANK);
  assign grant_write = (q_head[grant_idx] == KIND_WR);

  dram_timing_ctrs #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .RANK_W(RANK_W), .BANK_BUSY(BANK_BUSY),
    .BUS_BUSY(BUS_BUSY), .RD_TO_WR(RD_TO_WR), .RANK_SWITCH(RANK_SWITCH)
  ) u_timers (
    .clk(clk),
    .rst_n(rst_n),
    .fire(grant_valid),
    .fire_bank(grant_idx),
    .fire_rank(grant_rank),
    .fire_write(grant_write),
    .bank_free(bank_free),
    .bus_free(bus_free),
    .wr_free(wr_free),
    .newrank_free(newrank_free),
    .last_rank(last_rank)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iss_valid <= 1'b0;
      iss_bank  <= '0;
      iss_rank  <= '0;
      iss_write <= 1'b0;
    end else begin
      iss_valid <= grant_valid;
      iss_bank  <= grant_idx;
      iss_rank  <= grant_rank;
      iss_write <= grant_write;
    end
  end

  // ---------------- spacing checks on the issue strobe ----------------
  localparam int GMAX  = BANK_BUSY + BUS_BUSY + RD_TO_WR + RANK_SWITCH;
  localparam int GAP_W = $clog2(GMAX + 1);

  logic [GAP_W-1:0]  gap_any_q, gap_rd_q;
  logic              prev_rd_q;
  logic [RANK_W-1:0] prev_rank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_any_q   <= GAP_W'(GMAX);
      gap_rd_q    <= GAP_W'(GMAX);
      prev_rd_q   <= 1'b0;
      prev_rank_q <= '0;
    end else begin
      if (iss_valid) begin
        gap_any_q   <= GAP_W'(1);
        prev_rd_q   <= !iss_write;
        prev_rank_q <= iss_rank;
      end else if (gap_any_q != GAP_W'(GMAX)) begin
        gap_any_q <= gap_any_q + GAP_W'(1);
      end
      if (iss_valid && !iss_write)        gap_rd_q <= GAP_W'(1);
      else if (gap_rd_q != GAP_W'(GMAX))  gap_rd_q <= gap_rd_q + GAP_W'(1);
    end
  end

  p_bus_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (int'(gap_any_q) >= BUS_BUSY));

  p_wr_turn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_write) |-> (int'(gap_rd_q) >= BUS_BUSY + RD_TO_WR));

  p_rank_switch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_write && prev_rd_q && (iss_rank != prev_rank_q))
      |-> (int'(gap_any_q) >= BUS_BUSY + RANK_SWITCH));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
    logic [GAP_W-1:0] gap_bank_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                   gap_bank_q <= GAP_W'(GMAX);
      else if (iss_valid && iss_bank == BANK_W'(b)) gap_bank_q <= GAP_W'(1);
      else if (gap_bank_q != GAP_W'(GMAX))          gap_bank_q <= gap_bank_q + GAP_W'(1);
    end
    p_bank_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_bank == BANK_W'(b)) |-> (int'(gap_bank_q) >= BANK_BUSY));
  end
endmodule

// File: tb/dram_issue_arb_test.sv
`timescale 1ns/1ps
module dram_issue_arb_test;
  localparam int BANK_BUSY   = 6;
  localparam int BUS_BUSY    = 2;
  localparam int RD_TO_WR    = 1;
  localparam int RANK_SWITCH = 1;
  localparam int BPR         = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        iss_valid;
  logic [2:0]  iss_bank;
  logic [1:0]  iss_rank;
  logic        iss_write;

  always #2 clk = ~clk;

  dram_issue_arb uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .iss_valid(iss_valid), .iss_bank(iss_bank), .iss_rank(iss_rank), .iss_write(iss_write)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails = 0;
  int sent = 0;
  bit done = 0;

  int lg_cyc  [256];
  int lg_bank [256];
  int lg_rank [256];
  int lg_wr   [256];
  int nlog = 0;

  always @(negedge clk) begin
    if (rst_n && iss_valid && nlog < 256) begin
      lg_cyc[nlog]  = cyc;
      lg_bank[nlog] = int'(iss_bank);
      lg_rank[nlog] = int'(iss_rank);
      lg_wr[nlog]   = int'(iss_write);
      nlog++;
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // caller stands at a falling edge; returns at the falling edge after acceptance
  task automatic send(input logic [11:0] a, input logic w, output int acc, output int waited);
    req_addr  = a;
    req_write = w;
    req_valid = 1'b1;
    waited    = 0;
    #1;
    while (!req_ready) begin
      waited = 1;
      @(negedge clk);
      #1;
    end
    acc = cyc + 1;
    sent++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [11:0] mk(input int idx, input int salt);
    logic [11:0] a;
    a    = 12'(salt) & 12'hF8F;
    a[4] = idx[0];
    a[5] = idx[1];
    a[6] = idx[2];
    return a;
  endfunction

  // R1 with the default field positions: bank bit 4, rank bit 5, DIMM bit 6
  function automatic int exp_idx(input logic [11:0] a);
    return int'(a[6]) * 4 + int'(a[5]) * 2 + int'(a[4]);
  endfunction

  task automatic pair_gap(input int b1, input logic w1, input int b2, input logic w2,
                          input int exp_gap, input string what);
    int base, acc, wt;
    base = nlog;
    send(mk(b1, 0), w1, acc, wt);
    send(mk(b2, 0), w2, acc, wt);
    idle(14);
    chk({what, " gap"}, lg_cyc[base + 1] - lg_cyc[base], exp_gap);
    chk({what, " second bank"}, lg_bank[base + 1], b2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int base, acc, wt, acc4, wt4, acc5, min_gap;
    repeat (3) @(negedge clk);
    chk("R10 iss_valid during reset", int'(iss_valid), 0);
    chk("R10 req_ready during reset", int'(req_ready), 1);
    rst_n = 1'b1;
    idle(2);
    chk("R10 iss_valid after reset", int'(iss_valid), 0);
    chk("R10 req_ready after reset", int'(req_ready), 1);
    chk("R10 no spurious issue", nlog, 0);

    // R1 / R2 / R9: decode sweep with varied surrounding bits
    for (int i = 0; i < 16; i++) begin
      logic [11:0] a;
      a = mk(i % 8, i * 419 + 1443);
      base = nlog;
      send(a, logic'(i[0]), acc, wt);
      idle(10);
      chk("R9 one pulse per request", nlog - base, 1);
      chk("R1 bank index", lg_bank[base], exp_idx(a));
      chk("R1 rank", lg_rank[base], exp_idx(a) / BPR);
      chk("R9 write flag", lg_wr[base], i % 2);
      chk("R2 idle latency", lg_cyc[base], acc + 1);
    end

    pair_gap(0, 1'b0, 1, 1'b0, BUS_BUSY, "R5 read-read same rank");
    pair_gap(0, 1'b0, 1, 1'b1, BUS_BUSY + RD_TO_WR, "R6 read-write");
    pair_gap(0, 1'b1, 4, 1'b1, BUS_BUSY, "R6 write-write");
    pair_gap(0, 1'b1, 2, 1'b0, BUS_BUSY, "R7 write then other-rank read");
    pair_gap(0, 1'b0, 2, 1'b0, BUS_BUSY + RANK_SWITCH, "R7 read then other-rank read");

    // R3 / R4: order inside one bank and bank occupancy
    base = nlog;
    send(mk(3, 5), 1'b1, acc, wt);
    send(mk(3, 9), 1'b0, acc, wt);
    idle(16);
    chk("R3 first is write", lg_wr[base], 1);
    chk("R3 second is read", lg_wr[base + 1], 0);
    chk("R4 same-bank gap", lg_cyc[base + 1] - lg_cyc[base], BANK_BUSY);

    // R2 / R4 / R7: full queue, pop-through and head-of-line blocking
    base = nlog;
    send(mk(0, 0), 1'b0, acc, wt);
    send(mk(0, 0), 1'b0, acc, wt);
    send(mk(0, 0), 1'b0, acc, wt);
    send(mk(0, 0), 1'b0, acc4, wt4);
    send(mk(5, 0), 1'b0, acc5, wt);
    idle(30);
    chk("R2 full queue drops ready", wt4, 1);
    chk("R2 pop-through accept cycle", acc4, lg_cyc[base + 1]);
    chk("R2 later request held behind stall", acc5, acc4 + 1);
    chk("R7 other-rank read slot", lg_bank[base + 2], 5);
    chk("R7 rank switch gap", lg_cyc[base + 2] - lg_cyc[base + 1], BUS_BUSY + RANK_SWITCH);
    chk("R4 busy gap 1", lg_cyc[base + 1] - lg_cyc[base], BANK_BUSY);
    chk("R4 busy gap 2", lg_cyc[base + 3] - lg_cyc[base + 1], BANK_BUSY);
    chk("R4 busy gap 3", lg_cyc[base + 4] - lg_cyc[base + 3], BANK_BUSY);

    // R8: two heads ready together, arrival order opposite to round-robin order
    base = nlog;
    send(mk(4, 0), 1'b0, acc, wt);
    send(mk(3, 0), 1'b1, acc, wt);
    send(mk(1, 0), 1'b1, acc, wt);
    idle(20);
    chk("R8 after bank 4 pick bank 1", lg_bank[base + 1], 1);
    chk("R8 then bank 3", lg_bank[base + 2], 3);
    chk("R6 turnaround before the pair", lg_cyc[base + 1] - lg_cyc[base], BUS_BUSY + RD_TO_WR);

    base = nlog;
    send(mk(2, 0), 1'b0, acc, wt);
    send(mk(1, 0), 1'b1, acc, wt);
    send(mk(3, 0), 1'b1, acc, wt);
    idle(20);
    chk("R8 after bank 2 pick bank 3", lg_bank[base + 1], 3);
    chk("R8 then bank 1", lg_bank[base + 2], 1);

    // R9 / R5 over the whole run
    chk("R9 every request issued once", nlog, sent);
    min_gap = 1000;
    for (int k = 1; k < nlog; k++) begin
      if (lg_cyc[k] - lg_cyc[k - 1] < min_gap) min_gap = lg_cyc[k] - lg_cyc[k - 1];
    end
    chk("R5 no two issues closer than bus time", int'(min_gap >= BUS_BUSY), 1);

    finish_run();
  end
endmodule